// File: doc/BRIEF.md
# Serial EEPROM configuration loader

The block fills a set of configuration registers and a small address-PROM store from an external serial EEPROM, and it reports whether the image it read can be trusted. A read starts on its own as soon as hard reset is released. The host can start another read at any time the block is idle by writing the request bit of the control offset. Each read sends a read command followed by a zero start address. The block then checks the dummy bit that the EEPROM returns, streams the whole image in one sequential burst, and adds every image byte into an 8-bit checksum.

A read that passes the check commits the image to the outputs and raises the valid flag. A read that fails the checksum, or that finds no EEPROM on the data-out line, leaves the valid flag low and puts every EEPROM-programmable configuration register back to its hard-reset default. The address-PROM store keeps its earlier contents in that case.

The block also holds a sticky flag that selects 32-bit wide I/O. The host bus sets this flag by doing a 32-bit write to offset 10h. A successful image load also sets or clears it, using bit 15 of the first configuration word. Soft reset and the stop input leave both flags untouched.

Top module: `eeld_loader`

## Requirements
- R1: While hard reset is asserted and right after it, valid_o and wide_io_o are 0, cfg_o equals CFG_DEFAULT and ap_o is 0. At the first clock edge after release an automatic read starts, so busy_o is 1 from the next cycle on.
- R2: During a read ee_cs_o stays high for exactly 2*CLK_DIV*(3+ADDR_W+16*NUM_WORDS) clock cycles. Over the first 3+ADDR_W rising edges of ee_sk_o, ee_di_o carries 1,1,0 and then ADDR_W zero bits.
- R3: When the block is idle, a host write to offset CTRL_OFS with host_req_i=1 makes valid_o 0 and busy_o 1 on the next cycle. The same write is ignored while busy_o is 1.
- R4: Image word k arrives most significant bit first. The read passes when the 8-bit sum of the high and low bytes of all NUM_WORDS words is FFh. On a pass valid_o becomes 1, ap_o[16k+:16] takes word k for k < AP_WORDS, and cfg_o[16j+:16] takes word AP_WORDS+j.
- R5: A read whose byte sum is not FFh ends with valid_o 0 and cfg_o equal to CFG_DEFAULT, and ap_o keeps its earlier value.
- R6: If ee_do_i is 1 when the dummy bit is sampled (the end of the last address bit), the read ends after 2*CLK_DIV*(3+ADDR_W) cycles of ee_cs_o. It then behaves like a failed read. This applies to both automatic and host-requested reads.
- R7: busy_o returns to 0 on the cycle after a read ends, whether it passed or failed.
- R8: A host write with host_wide_i=1 to offset 10h sets wide_io_o on the next cycle. A 16-bit write to 10h, or a 32-bit write to any other offset, leaves it unchanged.
- R9: wide_io_o falls only through hard reset or through a passing read whose first configuration word has bit 15 at 0. A passing read copies that bit, and a failing read leaves the flag as it was.
- R10: A write to CTRL_OFS with host_req_i=0, or a write with host_req_i=1 to another offset, starts no read and changes neither flag.
- R11: soft_rst_i and stop_i have no effect on valid_o or wide_io_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low |
| soft_rst_i | input | 1 | Soft reset; flags and loaded state ignore it |
| stop_i | input | 1 | Stop control; flags and loaded state ignore it |
| host_wr_i | input | 1 | Host write strobe |
| host_wide_i | input | 1 | Current write is 32 bits wide |
| host_addr_i | input | 8 | Host I/O offset |
| host_req_i | input | 1 | Value written to the read-request bit |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data toward the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM, pulled high when absent |
| valid_o | output | 1 | Last read passed |
| busy_o | output | 1 | Read-request bit readback, 1 while a read runs |
| wide_io_o | output | 1 | Sticky 32-bit I/O mode flag |
| ap_o | output | AP_WORDS*16 | Address-PROM store |
| cfg_o | output | (NUM_WORDS-AP_WORDS-1)*16 | EEPROM-programmable configuration registers |

## Verification
The bench builds the loader with NUM_WORDS=4, AP_WORDS=1, ADDR_W=4 and CLK_DIV=1. One read then takes about 150 cycles, which makes it cheap to sweep all 256 values of the checksum byte: exactly one value passes, and every other value has to restore the defaults while keeping the address-PROM word. That sweep also cycles through many seeded images, so the mode bit comes through as both 0 and 1 while host wide writes are mixed in. With the small image, both the full-length and the cut-short chip-select windows can be counted exactly.

// File: rtl/eeld_pkg.sv
package eeld_pkg;
    localparam int WORD_W = 16;
    localparam logic [7:0] CHK_GOAL = 8'hFF;
    localparam int MODE_POS = 15;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_FIN  = 2'd2
    } eng_state_e;
endpackage

// File: rtl/eeld_serial_engine.sv
module eeld_serial_engine
    import eeld_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_WORDS = 8,
    parameter int CLK_DIV   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ee_do_i,
    output logic ee_cs_o,
    output logic ee_sk_o,
    output logic ee_di_o,
    output logic bit_stb_o,
    output logic bit_o,
    output logic done_o,
    output logic present_o
);
    localparam int HDR_SLOTS = 3 + ADDR_W;
    localparam int TOT_SLOTS = HDR_SLOTS + WORD_W * NUM_WORDS;
    localparam int SLOT_W    = $clog2(TOT_SLOTS);
    localparam int PH_W      = (CLK_DIV > 1) ? $clog2(2 * CLK_DIV) : 1;
    localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(2 * CLK_DIV - 1);
    localparam logic [PH_W-1:0]   PH_HIGH  = PH_W'(CLK_DIV);
    localparam logic [SLOT_W-1:0] HDR_LAST = SLOT_W'(HDR_SLOTS - 1);
    localparam logic [SLOT_W-1:0] DAT_FIRST = SLOT_W'(HDR_SLOTS);
    localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(TOT_SLOTS - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [PH_W-1:0]   ph;
        logic [SLOT_W-1:0] slot;
        logic              present;
    } eng_s;

    eng_s eng_d, eng_q;

    always_comb begin
        eng_d     = eng_q;
        bit_stb_o = 1'b0;
        done_o    = 1'b0;
        unique case (eng_q.st)
            ENG_IDLE: begin
                if (start_i) begin
                    eng_d.st      = ENG_RUN;
                    eng_d.ph      = '0;
                    eng_d.slot    = '0;
                    eng_d.present = 1'b1;
                end
            end
            ENG_RUN: begin
                if (eng_q.ph == PH_LAST) begin
                    eng_d.ph = '0;
                    if (eng_q.slot == HDR_LAST) begin
                        // dummy bit must read back as 0
                        if (ee_do_i) begin
                            eng_d.present = 1'b0;
                            eng_d.st      = ENG_FIN;
                        end else begin
                            eng_d.slot = eng_q.slot + 1'b1;
                        end
                    end else if (eng_q.slot >= DAT_FIRST) begin
                        bit_stb_o = 1'b1;
                        if (eng_q.slot == SLOT_END) begin
                            eng_d.st = ENG_FIN;
                        end else begin
                            eng_d.slot = eng_q.slot + 1'b1;
                        end
                    end else begin
                        eng_d.slot = eng_q.slot + 1'b1;
                    end
                end else begin
                    eng_d.ph = eng_q.ph + 1'b1;
                end
            end
            ENG_FIN: begin
                done_o   = 1'b1;
                eng_d.st = ENG_IDLE;
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ENG_IDLE, ph: '0, slot: '0, present: 1'b0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign ee_cs_o   = (eng_q.st == ENG_RUN);
    assign ee_sk_o   = ee_cs_o && (eng_q.ph >= PH_HIGH);
    // command: start bit 1, opcode 1 0, then an all-zero address
    assign ee_di_o   = ee_cs_o && (eng_q.slot < SLOT_W'(2));
    assign bit_o     = ee_do_i;
    assign present_o = eng_q.present;

    // R2
    cs_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs_o) |-> $past(start_i));

    // R6
    absent_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_cs_o && eng_q.ph == PH_LAST && eng_q.slot == HDR_LAST && ee_do_i)
        |=> !ee_cs_o && !present_o);
endmodule

// File: rtl/eeld_image_asm.sv
module eeld_image_asm
    import eeld_pkg::*;
#(
    parameter int NUM_WORDS = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clear_i,
    input  logic                               bit_stb_i,
    input  logic                               bit_i,
    output logic [(NUM_WORDS-1)*WORD_W-1:0]    image_o,
    output logic [7:0]                         sum_o
);
    localparam int STORE = NUM_WORDS - 1;
    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam int BC_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0]       sh;
        logic [BC_W-1:0]         bcnt;
        logic [IDX_W-1:0]        widx;
        logic [7:0]              sum;
        logic [STORE*WORD_W-1:0] img;
    } asm_s;

    asm_s asm_d, asm_q;
    logic [WORD_W-1:0] word_nx;

    always_comb begin
        asm_d   = asm_q;
        word_nx = {asm_q.sh[WORD_W-2:0], bit_i};
        if (clear_i) begin
            asm_d.bcnt = '0;
            asm_d.widx = '0;
            asm_d.sum  = '0;
        end else if (bit_stb_i) begin
            asm_d.sh = word_nx;
            if (asm_q.bcnt == BC_W'(WORD_W - 1)) begin
                asm_d.bcnt = '0;
                asm_d.widx = asm_q.widx + 1'b1;
                asm_d.sum  = asm_q.sum + word_nx[15:8] + word_nx[7:0];
                if (asm_q.widx < IDX_W'(STORE)) begin
                    asm_d.img[asm_q.widx*WORD_W +: WORD_W] = word_nx;
                end
            end else begin
                asm_d.bcnt = asm_q.bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q <= '0;
        end else begin
            asm_q <= asm_d;
        end
    end

    assign image_o = asm_q.img;
    assign sum_o   = asm_q.sum;
endmodule

// File: rtl/eeld_loader.sv
module eeld_loader
    import eeld_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_WORDS = 8,
    parameter int AP_WORDS  = 3,
    parameter int CLK_DIV   = 2,
    parameter logic [7:0] CTRL_OFS = 8'h4C,
    parameter logic [7:0] WIDE_OFS = 8'h10,
    parameter logic [(NUM_WORDS-AP_WORDS-1)*16-1:0] CFG_DEFAULT =
        {(NUM_WORDS-AP_WORDS-1){16'h5A3C}}
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     soft_rst_i,
    input  logic                                     stop_i,
    input  logic                                     host_wr_i,
    input  logic                                     host_wide_i,
    input  logic [7:0]                               host_addr_i,
    input  logic                                     host_req_i,
    output logic                                     ee_cs_o,
    output logic                                     ee_sk_o,
    output logic                                     ee_di_o,
    input  logic                                     ee_do_i,
    output logic                                     valid_o,
    output logic                                     busy_o,
    output logic                                     wide_io_o,
    output logic [AP_WORDS*16-1:0]                   ap_o,
    output logic [(NUM_WORDS-AP_WORDS-1)*16-1:0]     cfg_o
);
    localparam int AP_W  = AP_WORDS * WORD_W;
    localparam int CFG_W = (NUM_WORDS - AP_WORDS - 1) * WORD_W;
    localparam int IMG_W = (NUM_WORDS - 1) * WORD_W;
    localparam int MODE_BIT = AP_W + MODE_POS;

    typedef struct packed {
        logic             pend;
        logic             busy;
        logic             valid;
        logic             wide;
        logic [AP_W-1:0]  ap;
        logic [CFG_W-1:0] cfg;
    } ld_s;

    ld_s ld_d, ld_q;

    logic             start;
    logic             req_wr;
    logic             wide_wr;
    logic             eng_done;
    logic             eng_present;
    logic             bit_stb;
    logic             bit_val;
    logic             ld_ok;
    logic [IMG_W-1:0] image;
    logic [7:0]       img_sum;

    eeld_serial_engine #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS),
        .CLK_DIV  (CLK_DIV)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .ee_do_i  (ee_do_i),
        .ee_cs_o  (ee_cs_o),
        .ee_sk_o  (ee_sk_o),
        .ee_di_o  (ee_di_o),
        .bit_stb_o(bit_stb),
        .bit_o    (bit_val),
        .done_o   (eng_done),
        .present_o(eng_present)
    );

    eeld_image_asm #(
        .NUM_WORDS(NUM_WORDS)
    ) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start),
        .bit_stb_i(bit_stb),
        .bit_i    (bit_val),
        .image_o  (image),
        .sum_o    (img_sum)
    );

    assign req_wr  = host_wr_i && host_req_i && (host_addr_i == CTRL_OFS);
    assign wide_wr = host_wr_i && host_wide_i && (host_addr_i == WIDE_OFS);
    assign start   = !ld_q.busy && (ld_q.pend || req_wr);
    assign ld_ok   = eng_present && (img_sum == CHK_GOAL);

    always_comb begin
        ld_d = ld_q;
        if (start) begin
            ld_d.pend  = 1'b0;
            ld_d.busy  = 1'b1;
            ld_d.valid = 1'b0;
        end
        if (eng_done) begin
            ld_d.busy  = 1'b0;
            ld_d.valid = ld_ok;
            if (ld_ok) begin
                ld_d.ap   = image[AP_W-1:0];
                ld_d.cfg  = image[AP_W +: CFG_W];
                ld_d.wide = image[MODE_BIT];
            end else begin
                ld_d.cfg  = CFG_DEFAULT;
            end
        end
        if (wide_wr) begin
            ld_d.wide = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q <= '{pend: 1'b1, busy: 1'b0, valid: 1'b0, wide: 1'b0,
                      ap: '0, cfg: CFG_DEFAULT};
        end else begin
            ld_q <= ld_d;
        end
    end

    assign valid_o   = ld_q.valid;
    assign busy_o    = ld_q.busy;
    assign wide_io_o = ld_q.wide;
    assign ap_o      = ld_q.ap;
    assign cfg_o     = ld_q.cfg;

    // R3
    req_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !busy_o) |=> busy_o && !valid_o);

    // R4
    valid_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(eng_done && ld_ok));

    // R5
    fail_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !ld_ok) |=> (cfg_o == CFG_DEFAULT) && $stable(ap_o));

    // R7
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !busy_o);

    // R9
    wide_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wide_io_o) |-> $past(eng_done && ld_ok));

    // R11
    soft_stop_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((soft_rst_i || stop_i) && !eng_done && !start && !wide_wr)
        |=> $stable(valid_o) && $stable(wide_io_o));
endmodule

// File: tb/eeld_loader_tb.sv
module eeld_loader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NW   = 4;
    localparam int APW  = 1;
    localparam int ADW  = 4;
    localparam int DIV  = 1;
    localparam int HDR  = 3 + ADW;
    localparam int CFGW = (NW - APW - 1) * 16;
    localparam logic [7:0] CTRL = 8'h4C;
    localparam logic [CFGW-1:0] CDEF = 32'hC0DE_5A5A;
    localparam int FULL_CS = 2 * DIV * (HDR + 16 * NW);
    localparam int SHORT_CS = 2 * DIV * HDR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, stop = 1'b0;
    logic host_wr = 1'b0, host_wide = 1'b0, host_req = 1'b0;
    logic [7:0] host_addr = '0;
    logic cs_w, sk_w, di_w, do_w;
    logic valid, busy, wide;
    logic [APW*16-1:0] ap;
    logic [CFGW-1:0] cfg;

    logic [15:0] img [NW];
    logic present = 1'b1;
    logic mdl_do = 1'b1;
    int   rise_n = 0;
    logic [HDR-1:0] hdr_sh = '0;
    logic [HDR-1:0] hdr_last = '0;
    int   cs_cnt = 0;

    int tests = 0, fails = 0;
    logic [15:0] exp_ap;
    logic [CFGW-1:0] exp_cfg;
    logic exp_wide;
    logic exp_valid;
    int cs_snap;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign do_w = present ? mdl_do : 1'b1;

    eeld_loader #(
        .ADDR_W(ADW), .NUM_WORDS(NW), .AP_WORDS(APW), .CLK_DIV(DIV),
        .CTRL_OFS(CTRL), .WIDE_OFS(8'h10), .CFG_DEFAULT(CDEF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .stop_i(stop),
        .host_wr_i(host_wr), .host_wide_i(host_wide), .host_addr_i(host_addr),
        .host_req_i(host_req), .ee_cs_o(cs_w), .ee_sk_o(sk_w), .ee_di_o(di_w),
        .ee_do_i(do_w), .valid_o(valid), .busy_o(busy), .wide_io_o(wide),
        .ap_o(ap), .cfg_o(cfg)
    );

    // serial EEPROM model: samples DI and moves DO on each rising SK
    always @(posedge sk_w or negedge cs_w) begin
        if (!cs_w) begin
            rise_n = 0;
        end else begin
            if (rise_n < HDR) begin
                hdr_sh = {hdr_sh[HDR-2:0], di_w};
                if (rise_n == HDR - 1) begin
                    hdr_last = hdr_sh;
                    mdl_do = 1'b0;
                end
            end else begin
                mdl_do = img[(rise_n - HDR) / 16][15 - ((rise_n - HDR) % 16)];
            end
            rise_n = rise_n + 1;
        end
    end

    always @(negedge clk) if (cs_w) cs_cnt = cs_cnt + 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic build(input int seed, input int delta);
        logic [7:0] s;
        s = '0;
        for (int k = 0; k < NW - 1; k++) begin
            img[k] = 16'(seed * 40503 + k * 7919 + 16'h1234) ^ 16'(seed << k);
            s = s + img[k][15:8] + img[k][7:0];
        end
        img[NW-1][15:8] = 8'(seed * 3 + 1);
        s = s + img[NW-1][15:8];
        img[NW-1][7:0] = 8'hFF - s + 8'(delta);
    endtask

    task automatic host_write(input logic [7:0] a, input logic w32, input logic rq);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wide = w32; host_req = rq;
        @(negedge clk);
        host_wr = 1'b0; host_wide = 1'b0; host_req = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) chk("R7 busy timeout", 1, 0);
    endtask

    task automatic start_read();
        cs_snap = cs_cnt;
        host_write(CTRL, 1'b0, 1'b1);
        chk("R3 valid cleared", valid, 0);
        chk("R3 busy set", busy, 1);
    endtask

    task automatic check_after(input logic pass, input string tag);
        if (pass) begin
            exp_ap = img[0];
            exp_cfg = {img[2], img[1]};
            exp_wide = img[1][15];
        end else begin
            exp_cfg = CDEF;
        end
        chk({tag, " R4/R5 valid"}, valid, pass);
        chk({tag, " R4/R5 cfg"}, cfg, exp_cfg);
        chk({tag, " R4/R5 ap"}, ap, exp_ap);
        chk({tag, " R9 wide"}, wide, exp_wide);
        chk({tag, " R7 busy"}, busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        exp_ap = '0; exp_cfg = CDEF; exp_wide = 1'b0; exp_valid = 1'b0;
        build(5, 0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", valid, 0);
        chk("R1 wide", wide, 0);
        chk("R1 cfg", cfg, CDEF);
        chk("R1 ap", ap, 0);
        chk("R1 cs", cs_w, 0);
        cs_snap = cs_cnt;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 auto start busy", busy, 1);
        wait_idle();
        check_after(1'b1, "auto");
        chk("R2 cs window", cs_cnt - cs_snap, FULL_CS);
        chk("R2 header bits", hdr_last, 7'b1100000);

        // seeded images, all with a correct checksum
        for (int s = 0; s < 16; s++) begin
            build(s * 7 + 3, 0);
            start_read();
            wait_idle();
            check_after(1'b1, "R4 seed");
            chk("R2 cs window seed", cs_cnt - cs_snap, FULL_CS);
        end

        // exhaustive sweep of the checksum byte; only offset 0 passes
        for (int d = 0; d < 256; d++) begin
            build(d, d);
            if (d % 4 == 1) begin
                host_write(8'h10, 1'b1, 1'b0);
                exp_wide = 1'b1;
                chk("R8 wide write sets", wide, 1);
            end else if (d % 4 == 2) begin
                host_write(8'h10, 1'b0, 1'b0);
                host_write(8'h18, 1'b1, 1'b0);
                chk("R8 non-matching write", wide, exp_wide);
            end
            start_read();
            wait_idle();
            check_after(d == 0, "R5 sweep");
        end

        // R3 request while busy is ignored
        build(77, 0);
        start_read();
        repeat (10) @(negedge clk);
        host_write(CTRL, 1'b0, 1'b1);
        wait_idle();
        check_after(1'b1, "R3 busy req");
        repeat (6) @(negedge clk);
        chk("R3 no second read", busy, 0);

        // R10 writes that must not start a read or touch flags
        host_write(CTRL, 1'b1, 1'b0);
        chk("R10 ctrl no req busy", busy, 0);
        chk("R10 ctrl no req valid", valid, 1);
        host_write(8'h20, 1'b0, 1'b1);
        chk("R10 other ofs busy", busy, 0);
        chk("R10 other ofs valid", valid, 1);
        chk("R10 wide kept", wide, exp_wide);

        // R11 soft reset and stop
        host_write(8'h10, 1'b1, 1'b0);
        exp_wide = 1'b1;
        soft_rst = 1'b1; stop = 1'b1;
        repeat (20) @(negedge clk);
        chk("R11 valid", valid, 1);
        chk("R11 wide", wide, 1);
        soft_rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R11 stop only wide", wide, 1);
        stop = 1'b0;

        // R6 absent EEPROM on a host request
        present = 1'b0;
        start_read();
        wait_idle();
        check_after(1'b0, "R6 absent");
        chk("R6 short cs window", cs_cnt - cs_snap, SHORT_CS);

        // hard reset clears the sticky flag, then auto read with no EEPROM
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 hard reset wide", wide, 0);
        chk("R1 reset ap", ap, 0);
        chk("R1 reset cfg", cfg, CDEF);
        exp_ap = '0; exp_wide = 1'b0;
        cs_snap = cs_cnt;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 auto busy", busy, 1);
        wait_idle();
        check_after(1'b0, "R6 auto absent");
        chk("R6 auto short cs", cs_cnt - cs_snap, SHORT_CS);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule